// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences a small processor system between its running state and two low-power states. The CPU signals that it wants to wait for an interrupt, and a select input, sampled in that same cycle, chooses a light sleep or a deep stop. In light sleep only the CPU clock is gated; peripherals and oscillators keep running. In deep stop every core-domain clock and all three oscillator enables (PLL, internal RC, external crystal) are dropped, and register and memory contents are kept because the block never issues a reset.

Nineteen wakeup lines bring the system back: sixteen external interrupt lines and three on-chip sources (a real-time clock line, an I2C line and a USART line), each with its own mask bit. While the system is stopped, either communication peripheral may ask for the internal RC oscillator so that it can clock incoming data. That request turns on the RC oscillator and that peripheral's own clock, and it leaves the CPU asleep. On a real wakeup from stop the RC oscillator is enabled first, and the CPU clock is released only once the RC oscillator reports ready. Turning the PLL and crystal back on is left to software through two software enable inputs.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After a cycle with rst_n low, mode is 2'b00 (run), cpu_clk_en, per_clk_en, rc_en and both req_clk_en bits are 1, and pll_en and xtal_en equal pll_sw_en and xtal_sw_en.
- R2: In run, a cycle with wfi_req=1, deep_sel=0 and no unmasked wake line gives, from the next cycle, mode 2'b01 with cpu_clk_en=0 and per_clk_en, rc_en, req_clk_en all 1, and pll_en/xtal_en still following the software enables.
- R3: In sleep, a cycle with any unmasked wake line returns the block to run (mode 2'b00, cpu_clk_en=1) in the next cycle.
- R4: In run, a cycle with wfi_req=1, deep_sel=1 and no unmasked wake line gives, from the next cycle, mode 2'b10 with cpu_clk_en, per_clk_en, pll_en and xtal_en all 0, whatever the software enables are.
- R5: In stop, while no wakeup has been taken, rc_en equals the OR of osc_req and req_clk_en[k] equals osc_req[k] in the same cycle (bit 0 is the I2C request, bit 1 the USART request); cpu_clk_en stays 0 and mode stays 2'b10.
- R6: In stop, an unmasked wake line gives rc_en=1 from the next cycle with the CPU still gated and mode 2'b10; the block waits while rc_ready=0, and the cycle after rc_ready is sampled 1 it is back in run with cpu_clk_en=1. pll_en and xtal_en stay 0 until run is reached.
- R7: A cycle in run with wfi_req=1 and an unmasked wake line aborts the entry: the block stays in run.
- R8: Wake line i is ignored when wake_mask[i]=1 (mask 1 means disabled), on entry, in sleep and in stop; lines 16, 17 and 18 are the RTC, I2C and USART sources.
- R9: mode encodes run as 2'b00, sleep as 2'b01, and both stop and the wait for RC ready as 2'b10.
- R10: wfi_req and deep_sel have no effect outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | CPU wait-for-interrupt request |
| deep_sel | input | 1 | 0 selects light sleep, 1 deep stop; sampled with wfi_req |
| pll_sw_en | input | 1 | Software PLL enable, honoured in run and sleep |
| xtal_sw_en | input | 1 | Software crystal enable, honoured in run and sleep |
| wake_lines | input | 19 | Wakeup lines: 0-15 external, 16 RTC, 17 I2C, 18 USART |
| wake_mask | input | 19 | Per-line mask, 1 ignores the line |
| osc_req | input | 2 | RC oscillator requests in stop: bit 0 I2C, bit 1 USART |
| rc_ready | input | 1 | Internal RC oscillator is stable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Common peripheral clock enable |
| req_clk_en | output | 2 | Clock enable of each requesting peripheral |
| pll_en | output | 1 | PLL enable |
| rc_en | output | 1 | Internal RC oscillator enable |
| xtal_en | output | 1 | External crystal oscillator enable |
| mode | output | 2 | Current mode: 00 run, 01 sleep, 10 stop |

## Verification
The hardest situation to reach is the exit from stop while a peripheral is already holding the RC oscillator on and rc_ready is either held low for several cycles or already high, because it needs a deep entry with every line masked or quiet, then a request, then an unmasked wake, in that order. Directed sequences walk that path with rc_ready held low and then raised, and a wake line raised in the very cycle of a request checks the abort. Random stimulus then keeps wake lines rare and masks about half of them so that sleep and stop last long enough for requests, masked lines and stray wfi_req pulses to land inside them, with every cycle compared against a bench model.

// File: rtl/lpm_pkg.sv
// Package: shared state type and mode codes of the low-power controller.
// Assumes: mode codes are decoded by software and must not change.
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_STOP  = 2'b10,
        ST_WAKE  = 2'b11
    } lpm_state_e;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_SLEEP = 2'b01;
    localparam logic [1:0] MODE_STOP  = 2'b10;

endpackage

// File: rtl/lpm_wake_detect.sv
// Module: qualifies each wakeup line with its mask bit and reduces the
// result to one wake indication.
// Assumes: lines are already synchronous to clk; mask bit 1 disables a line.
module lpm_wake_detect #(
    parameter int N_WAKE = 19
) (
    input  logic [N_WAKE-1:0] lines,
    input  logic [N_WAKE-1:0] mask,
    output logic              hit
);

    logic [N_WAKE-1:0] qual;

    // Per-line qualification by the mask bit.
    for (genvar i = 0; i < N_WAKE; i++) begin : g_line
        assign qual[i] = lines[i] & ~mask[i];
    end

    // Any qualified line is a wakeup.
    always_comb begin
        hit = |qual;
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
// Module: mode sequencer. Moves between run, sleep, stop and the wait for
// the RC oscillator after stop.
// Assumes: wake_hit is already masked; wfi_req is honoured only in run.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_req,
    input  logic       deep_sel,
    input  logic       wake_hit,
    input  logic       rc_ready,
    output lpm_state_e state
);

    lpm_state_e state_nxt;

    // Next-state selection.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (wfi_req && !wake_hit) begin
                    state_nxt = deep_sel ? ST_STOP : ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (wake_hit) state_nxt = ST_RUN;
            end
            ST_STOP: begin
                if (wake_hit) state_nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (rc_ready) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_hit) |=> (state == ST_RUN)); // R3

    AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wfi_req && wake_hit) |=> (state == ST_RUN)); // R7

    AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && !rc_ready) |=> (state == ST_WAKE)); // R6

    AST_READY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && rc_ready) |=> (state == ST_RUN)); // R6

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wake_hit) |=> (state == ST_STOP)); // R8

    AST_NO_STRAY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !wake_hit) |=> (state == ST_SLEEP)); // R10

endmodule

// File: rtl/lpm_gate_decode.sv
// Module: turns the sequencer state into clock and oscillator enables.
// Assumes: osc_req is only meaningful while stopped; in run and sleep every
// peripheral clock is already on.
module lpm_gate_decode
    import lpm_pkg::*;
#(
    parameter int N_REQ = 2
) (
    input  lpm_state_e       state,
    input  logic             pll_sw_en,
    input  logic             xtal_sw_en,
    input  logic [N_REQ-1:0] osc_req,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic [N_REQ-1:0] req_clk_en,
    output logic             pll_en,
    output logic             rc_en,
    output logic             xtal_en,
    output logic [1:0]       mode
);

    logic awake_osc;
    logic stopped;

    // Core enables from the state.
    always_comb begin
        awake_osc  = (state == ST_RUN) || (state == ST_SLEEP);
        stopped    = (state == ST_STOP) || (state == ST_WAKE);
        cpu_clk_en = (state == ST_RUN);
        per_clk_en = awake_osc;
        pll_en     = awake_osc && pll_sw_en;
        xtal_en    = awake_osc && xtal_sw_en;
        rc_en      = awake_osc || (state == ST_WAKE) || (stopped && |osc_req);
    end

    // Per-requester clock: on with the common clock or its own request.
    for (genvar k = 0; k < N_REQ; k++) begin : g_req
        assign req_clk_en[k] = awake_osc || (stopped && osc_req[k]);
    end

    // Mode code: the wait for RC ready still reports stop.
    always_comb begin
        unique case (state)
            ST_RUN:   mode = MODE_RUN;
            ST_SLEEP: mode = MODE_SLEEP;
            default:  mode = MODE_STOP;
        endcase
    end

endmodule

// File: rtl/lpm_clk_ctrl.sv
// Module: top of the low-power mode clock controller. Combines the wake
// qualification, the mode sequencer and the enable decode.
// Assumes: all inputs synchronous to the always-on clk; no reset is ever
// issued on exit from a low-power mode.
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter  int N_EXT  = 16,
    parameter  int N_INT  = 3,
    parameter  int N_REQ  = 2,
    localparam int N_WAKE = N_EXT + N_INT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wfi_req,
    input  logic              deep_sel,
    input  logic              pll_sw_en,
    input  logic              xtal_sw_en,
    input  logic [N_WAKE-1:0] wake_lines,
    input  logic [N_WAKE-1:0] wake_mask,
    input  logic [N_REQ-1:0]  osc_req,
    input  logic              rc_ready,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic [N_REQ-1:0]  req_clk_en,
    output logic              pll_en,
    output logic              rc_en,
    output logic              xtal_en,
    output logic [1:0]        mode
);

    logic       wake_hit;
    lpm_state_e state;

    lpm_wake_detect #(.N_WAKE(N_WAKE)) u_wake (
        .lines (wake_lines),
        .mask  (wake_mask),
        .hit   (wake_hit)
    );

    lpm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wfi_req  (wfi_req),
        .deep_sel (deep_sel),
        .wake_hit (wake_hit),
        .rc_ready (rc_ready),
        .state    (state)
    );

    lpm_gate_decode #(.N_REQ(N_REQ)) u_dec (
        .state      (state),
        .pll_sw_en  (pll_sw_en),
        .xtal_sw_en (xtal_sw_en),
        .osc_req    (osc_req),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .req_clk_en (req_clk_en),
        .pll_en     (pll_en),
        .rc_en      (rc_en),
        .xtal_en    (xtal_en),
        .mode       (mode)
    );

    AST_STOP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP) |-> (!pll_en && !xtal_en && !cpu_clk_en && !per_clk_en)); // R4

    AST_REQ_NEEDS_RC: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_clk_en && !per_clk_en) |-> rc_en); // R5

    AST_CPU_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (mode == MODE_RUN)); // R9

    AST_SLEEP_KEEPS_PER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP) |-> (per_clk_en && rc_en && !cpu_clk_en)); // R2

endmodule

// File: tb/lpm_clk_ctrl_tb.sv
// Bench: directed corner cases then seeded random stimulus, every cycle
// compared against a bench model of the requirements.
module lpm_clk_ctrl_tb_top;

    localparam int NW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wfi_req = 1'b0, deep_sel = 1'b0;
    logic          pll_sw_en = 1'b0, xtal_sw_en = 1'b0;
    logic [NW-1:0] wake_lines = '0, wake_mask = '0;
    logic [1:0]    osc_req = '0;
    logic          rc_ready = 1'b0;
    logic          cpu_clk_en, per_clk_en, pll_en, rc_en, xtal_en;
    logic [1:0]    req_clk_en, mode;

    int unsigned total = 0, bad = 0, cycles = 0;
    int          m_st = 0;   // 0 run, 1 sleep, 2 stop, 3 waiting for RC
    string       tag = "R1";

    always #4 clk = ~clk;

    lpm_clk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .deep_sel(deep_sel),
        .pll_sw_en(pll_sw_en), .xtal_sw_en(xtal_sw_en),
        .wake_lines(wake_lines), .wake_mask(wake_mask), .osc_req(osc_req),
        .rc_ready(rc_ready), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .req_clk_en(req_clk_en), .pll_en(pll_en), .rc_en(rc_en),
        .xtal_en(xtal_en), .mode(mode)
    );

    function automatic logic [8:0] exp_out(int st, logic psw, logic xsw, logic [1:0] rq);
        logic awake, stp, rc;
        logic [1:0] rce, md;
        awake = (st == 0) || (st == 1);
        stp   = (st == 2) || (st == 3);
        rc    = awake || (st == 3) || (stp && |rq);
        rce   = awake ? 2'b11 : rq;
        md    = (st == 0) ? 2'b00 : (st == 1) ? 2'b01 : 2'b10;
        return {st == 0, awake, awake && psw, awake && xsw, rc, rce, md};
    endfunction

    function automatic int nxt_st(int st, logic rn, logic wfi, logic dp, logic hit, logic rdy);
        if (!rn) return 0;
        case (st)
            0: return (wfi && !hit) ? (dp ? 2 : 1) : 0;
            1: return hit ? 0 : 1;
            2: return hit ? 3 : 2;
            default: return rdy ? 0 : 3;
        endcase
    endfunction

    // One cycle: inputs already set after a falling edge; check, then advance.
    task automatic tick(input bit do_chk = 1'b1);
        logic [8:0] act, expv;
        #2;
        if (do_chk) begin
            act  = {cpu_clk_en, per_clk_en, pll_en, xtal_en, rc_en, req_clk_en, mode};
            expv = exp_out(m_st, pll_sw_en, xtal_sw_en, osc_req);
            total++;
            if (act !== expv) begin
                bad++;
                $display("FAIL %s: outputs act=%b exp=%b (cpu,per,pll,xtal,rc,req[1:0],mode[1:0])",
                         tag, act, expv);
            end
        end
        @(posedge clk);
        m_st = nxt_st(m_st, rst_n, wfi_req, deep_sel,
                      |(wake_lines & ~wake_mask), rc_ready);
        @(negedge clk);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog: act=expired exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        tick(1'b0);
        tick(1'b0);
        rst_n = 1'b1;
        // R1: reset state, software enables passed in run
        tag = "R1"; pll_sw_en = 1'b1; xtal_sw_en = 1'b0; tick();
        xtal_sw_en = 1'b1; tick();
        // R7: wake in the entry cycle aborts
        tag = "R7"; wfi_req = 1'b1; wake_lines[3] = 1'b1; tick();
        wfi_req = 1'b0; wake_lines = '0; tick();
        // R8: masked line does not abort entry; enter sleep
        tag = "R8"; wake_mask[5] = 1'b1; wake_lines[5] = 1'b1; wfi_req = 1'b1; tick();
        tag = "R2"; wfi_req = 1'b0; tick(); tick();
        // R10: wfi and deep_sel ignored in sleep
        tag = "R10"; wfi_req = 1'b1; deep_sel = 1'b1; tick(); wfi_req = 1'b0; tick();
        // R3: unmasked RTC line wakes from sleep
        tag = "R3"; wake_lines = '0; wake_lines[16] = 1'b1; tick();
        wake_lines = '0; tick();
        // R4: deep entry with software enables on
        tag = "R4"; wfi_req = 1'b1; deep_sel = 1'b1; tick();
        wfi_req = 1'b0; deep_sel = 1'b0; tick(); tick();
        // R5: each peripheral oscillator request
        tag = "R5"; osc_req = 2'b01; tick(); osc_req = 2'b10; tick();
        osc_req = 2'b11; tick(); osc_req = 2'b00; tick();
        // R8: masked USART line ignored in stop
        tag = "R8"; wake_mask = '0; wake_mask[18] = 1'b1; wake_lines[18] = 1'b1; tick(); tick();
        // R6: unmasked I2C line, RC slow to become ready
        tag = "R6"; wake_lines[17] = 1'b1; osc_req = 2'b01; tick();
        wake_lines = '0; tick(); tick(); tick();
        tag = "R9"; tick();
        tag = "R6"; osc_req = 2'b00; rc_ready = 1'b1; tick(); tick(); rc_ready = 1'b0; tick();
        // R6: RC already ready when the wake is taken
        tag = "R6"; wfi_req = 1'b1; deep_sel = 1'b1; wake_mask = '0; tick();
        wfi_req = 1'b0; rc_ready = 1'b1; osc_req = 2'b10; tick();
        wake_lines[0] = 1'b1; tick(); wake_lines = '0; tick(); tick();
        osc_req = 2'b00; rc_ready = 1'b0;
        // R1: reset from sleep returns to run
        tag = "R1"; wfi_req = 1'b1; deep_sel = 1'b0; tick(); wfi_req = 1'b0;
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        // R9: seeded random traffic against the model
        tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            wfi_req    = ($urandom % 4) == 0;
            deep_sel   = $urandom % 2;
            pll_sw_en  = $urandom % 2;
            xtal_sw_en = $urandom % 2;
            rc_ready   = $urandom % 2;
            osc_req    = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
            wake_mask  = NW'($urandom);
            wake_lines = (($urandom % 6) == 0) ? (NW'(1) << ($urandom % NW)) : '0;
            tick();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule